// File: doc/BRIEF.md
# Registered Four-Function Arithmetic/Logic Datapath

This block is a small clocked datapath. Two operand registers capture a pair of input words. A combinational unit combines the held operands, and a result register holds the answer. Two select inputs choose the function: sum, difference, bitwise AND or bitwise OR. A single enable input gates every register in the block, so the datapath can be frozen between operations.

A build-time parameter chooses when the result is captured. In the default timing, the operands load on one rising clock edge and the result loads on the next rising edge, which gives two cycles from input to output. In the fast timing, the result register captures on the falling edge that follows the operand capture, so the answer is visible half a cycle after the operands load. The select bits are not registered. They feed the combinational unit directly and must be valid when the result register captures.

Top module: `regalu_top`

## Requirements
- R1: While `rst` is high at a capture edge, the operand registers and `c_out` are cleared to zero.
- R2: Select `{math_sel,sub_sel}` = 2'b10 produces the sum of the held operands, modulo 2^WIDTH.
- R3: Select 2'b11 produces the held A minus the held B, formed as A + ~B + 1 and truncated to WIDTH bits (for example 2 - 7 gives 4'hB).
- R4: Select 2'b00 produces the bitwise AND of the held operands.
- R5: Select 2'b01 produces the bitwise OR of the held operands.
- R6: With `en` low, no register changes: `c_out` holds, and the operand registers keep the values they held before `en` fell.
- R7: With FAST_MODE=0, an operand loads on a rising edge with `en` high, and `c_out` shows its result after the following rising edge, not before.
- R8: With FAST_MODE=1, `c_out` captures the unit's output on the falling edge after the rising edge that loaded the operands.
- R9: Reset takes precedence over `en`. With both high, the registers clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; operands load on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Load enable shared by every register |
| math_sel | input | 1 | 1 selects an arithmetic function, 0 a bitwise one |
| sub_sel | input | 1 | Chooses difference/OR (1) or sum/AND (0) |
| a_in | input | WIDTH | Operand A input word |
| b_in | input | WIDTH | Operand B input word |
| c_out | output | WIDTH | Registered result |

## Verification
The bench builds two copies side by side with the same stimulus: one with FAST_MODE=0 and one with FAST_MODE=1, both at WIDTH=4. Running both on one input stream makes the one-edge difference in result capture directly observable. It also lets each copy be checked at its own capture point. With a 4-bit width, the wrap of sums and differences and the all-ones and all-zero patterns can all be driven from a short vector table. A stalled enable window then shows whether stale operands or fresh inputs reach the result.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

    localparam int unsigned DATA_W = 4;

    typedef struct packed {
        logic math;
        logic sub;
    } sel_t;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;

    function automatic alu_op_e decode_sel(sel_t s);
        return alu_op_e'({s.math, s.sub});
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/regalu_opreg.sv
module regalu_opreg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/regalu_core.sv
module regalu_core
    import regalu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    logic          invert_b;
    logic [W-1:0]  b_eff;
    logic [W-1:0]  cy;
    logic [W-1:0]  sum;

    assign invert_b = (op == OP_SUB);
    assign b_eff    = b ^ {W{invert_b}};
    assign cy[0]    = invert_b;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign sum[i] = a[i] ^ b_eff[i] ^ cy[i];
            if (i < W - 1) begin : g_carry
                assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
            end
        end
    endgenerate

    always_comb begin
        if (is_arith(op)) begin
            y = sum;
        end else if (op == OP_OR) begin
            y = a | b;
        end else begin
            y = a & b;
        end
    end

endmodule

// File: rtl/regalu_resreg.sv
module regalu_resreg #(
    parameter int unsigned W        = 4,
    parameter bit          NEG_EDGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (NEG_EDGE) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (en) begin
                    q <= d;
                end
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (en) begin
                    q <= d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/regalu_top.sv
module regalu_top
    import regalu_pkg::*;
#(
    parameter int unsigned WIDTH     = DATA_W,
    parameter bit          FAST_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             math_sel,
    input  logic             sub_sel,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] c_out
);

    localparam int unsigned N_OPND = 2;

    logic [WIDTH-1:0] opnd_d [N_OPND];
    logic [WIDTH-1:0] opnd_q [N_OPND];
    logic [WIDTH-1:0] opa_q;
    logic [WIDTH-1:0] opb_q;
    logic [WIDTH-1:0] alu_y;
    sel_t             sel;
    alu_op_e          op;

    assign opnd_d[0] = a_in;
    assign opnd_d[1] = b_in;

    genvar k;
    generate
        for (k = 0; k < N_OPND; k++) begin : g_opnd
            regalu_opreg #(.W(WIDTH)) u_reg (
                .clk (clk),
                .rst (rst),
                .en  (en),
                .d   (opnd_d[k]),
                .q   (opnd_q[k])
            );
        end
    endgenerate

    assign opa_q = opnd_q[0];
    assign opb_q = opnd_q[1];

    assign sel.math = math_sel;
    assign sel.sub  = sub_sel;
    assign op       = decode_sel(sel);

    regalu_core #(.W(WIDTH)) u_core (
        .a  (opa_q),
        .b  (opb_q),
        .op (op),
        .y  (alu_y)
    );

    regalu_resreg #(.W(WIDTH), .NEG_EDGE(FAST_MODE)) u_res (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (alu_y),
        .q   (c_out)
    );

endmodule

// File: rtl/regalu_chk.sv
module regalu_chk #(
    parameter int unsigned W    = 4,
    parameter bit          FAST = 1'b0
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         math_sel,
    input logic         sub_sel,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q,
    input logic [W-1:0] c_out
);

    function automatic logic [W-1:0] expect_f(logic [W-1:0] a, logic [W-1:0] b,
                                             logic m, logic s);
        if (m) return s ? (a - b) : (a + b);
        return s ? (a | b) : (a & b);
    endfunction

    // R6: operand registers hold while enable is low
    p_opnd_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(a_q) && $stable(b_q)));

    // R7: operand registers take the inputs on an enabled rising edge
    p_opnd_load_r7: assert property (@(posedge clk) disable iff (rst)
        en |=> (a_q == $past(a_in) && b_q == $past(b_in)));

    // R1 / R9: reset clears operand registers even with enable high
    p_opnd_clear_r9: assert property (@(posedge clk)
        rst |=> (a_q == '0 && b_q == '0));

    generate
        if (FAST) begin : g_fast
            // R8: falling-edge capture of the function of held operands
            p_fast_result_r8: assert property (@(negedge clk) disable iff (rst)
                en |=> (c_out == expect_f($past(a_q), $past(b_q),
                                          $past(math_sel), $past(sub_sel))));
            // R6: result holds while enable is low
            p_fast_hold_r6: assert property (@(negedge clk) disable iff (rst)
                !en |=> $stable(c_out));
            // R1: result clears under reset
            p_fast_clear_r1: assert property (@(negedge clk)
                rst |=> (c_out == '0));
        end else begin : g_slow
            // R7: rising-edge capture of the function of held operands
            p_slow_result_r7: assert property (@(posedge clk) disable iff (rst)
                en |=> (c_out == expect_f($past(a_q), $past(b_q),
                                          $past(math_sel), $past(sub_sel))));
            // R6: result holds while enable is low
            p_slow_hold_r6: assert property (@(posedge clk) disable iff (rst)
                !en |=> $stable(c_out));
            // R1: result clears under reset
            p_slow_clear_r1: assert property (@(posedge clk)
                rst |=> (c_out == '0));
        end
    endgenerate

endmodule

bind regalu_top regalu_chk #(.W(WIDTH), .FAST(FAST_MODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .math_sel (math_sel),
    .sub_sel  (sub_sel),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_q      (opa_q),
    .b_q      (opb_q),
    .c_out    (c_out)
);

// File: tb/sim_regalu_top.sv
module sim_regalu_top;

    localparam int PERIOD = 10;
    localparam int NVEC   = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       math_sel = 1'b0;
    logic       sub_sel = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic [3:0] c_slow;
    logic [3:0] c_fast;

    int checks = 0;
    int failures = 0;

    always #(PERIOD/2) clk = ~clk;

    regalu_top #(.WIDTH(4), .FAST_MODE(1'b0)) u0 (
        .clk(clk), .rst(rst), .en(en), .math_sel(math_sel), .sub_sel(sub_sel),
        .a_in(a_in), .b_in(b_in), .c_out(c_slow)
    );

    regalu_top #(.WIDTH(4), .FAST_MODE(1'b1)) u1 (
        .clk(clk), .rst(rst), .en(en), .math_sel(math_sel), .sub_sel(sub_sel),
        .a_in(a_in), .b_in(b_in), .c_out(c_fast)
    );

    // {a, b, math, sub, expected}
    localparam logic [13:0] VEC [NVEC] = '{
        {4'h0, 4'hF, 1'b0, 1'b1, 4'hF},   // R5 all-ones OR
        {4'h3, 4'h5, 1'b1, 1'b0, 4'h8},   // R2
        {4'h9, 4'h9, 1'b1, 1'b0, 4'h2},   // R2 wrap
        {4'hF, 4'h1, 1'b1, 1'b0, 4'h0},   // R2 wrap to zero
        {4'h7, 4'h2, 1'b1, 1'b1, 4'h5},   // R3
        {4'h2, 4'h7, 1'b1, 1'b1, 4'hB},   // R3 negative
        {4'h0, 4'h1, 1'b1, 1'b1, 4'hF},   // R3 borrow all
        {4'h8, 4'h8, 1'b1, 1'b1, 4'h0},   // R3 equal
        {4'hC, 4'hA, 1'b0, 1'b0, 4'h8},   // R4
        {4'h5, 4'hA, 1'b0, 1'b0, 4'h0},   // R4 disjoint
        {4'hC, 4'h3, 1'b0, 1'b1, 4'hF},   // R5
        {4'h6, 4'h1, 1'b0, 1'b1, 4'h7}    // R5
    };

    function automatic string req_of(logic m, logic s);
        if (m) return s ? "R3" : "R2";
        return s ? "R5" : "R4";
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rise_step();
        @(posedge clk);
        #1;
    endtask

    task automatic fall_step();
        @(negedge clk);
        #1;
    endtask

    task automatic drive(logic [3:0] a, logic [3:0] b, logic m, logic s);
        a_in = a;
        b_in = b;
        math_sel = m;
        sub_sel = s;
    endtask

    initial begin
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) rise_step();
        check("R1 slow reset", c_slow, 4'h0);
        check("R1 fast reset", c_fast, 4'h0);
        rst = 1'b0;
        en = 1'b1;

        // Vector table: each input held two cycles
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][13:10], VEC[i][9:6], VEC[i][5], VEC[i][4]);
            rise_step();
            fall_step();
            check({req_of(VEC[i][5], VEC[i][4]), " fast"}, c_fast, VEC[i][3:0]);
            rise_step();
            check({req_of(VEC[i][5], VEC[i][4]), " slow"}, c_slow, VEC[i][3:0]);
        end

        // R7 / R8: latency with control held, only operands change
        drive(4'h0, 4'h0, 1'b0, 1'b1);
        rise_step();
        rise_step();
        check("R7 settle zero", c_slow, 4'h0);
        drive(4'h0, 4'hF, 1'b0, 1'b1);
        rise_step();
        check("R7 slow not yet", c_slow, 4'h0);
        check("R8 fast not before fall", c_fast, 4'h0);
        fall_step();
        check("R8 fast after fall", c_fast, 4'hF);
        check("R7 slow still old", c_slow, 4'h0);
        rise_step();
        check("R7 slow after second rise", c_slow, 4'hF);

        // R6: enable low freezes result and operands
        drive(4'h3, 4'h5, 1'b1, 1'b0);
        rise_step();
        rise_step();
        check("R2 pre-hold slow", c_slow, 4'h8);
        check("R2 pre-hold fast", c_fast, 4'h8);
        en = 1'b0;
        drive(4'hF, 4'hF, 1'b0, 1'b1);
        repeat (3) rise_step();
        check("R6 slow hold", c_slow, 4'h8);
        check("R6 fast hold", c_fast, 4'h8);
        // held operands 3,5 (not F,F) must reach the slow result
        en = 1'b1;
        drive(4'h1, 4'h1, 1'b1, 1'b0);
        rise_step();
        check("R6 operands held", c_slow, 4'h8);
        fall_step();
        check("R8 fast after resume", c_fast, 4'h2);

        // R9: reset with enable high
        rst = 1'b1;
        drive(4'hF, 4'hE, 1'b0, 1'b1);
        rise_step();
        check("R9 slow cleared", c_slow, 4'h0);
        fall_step();
        check("R9 fast cleared", c_fast, 4'h0);
        rise_step();
        rst = 1'b0;
        en = 1'b0;
        repeat (2) rise_step();
        check("R6 slow stays cleared", c_slow, 4'h0);
        check("R6 fast stays cleared", c_fast, 4'h0);

        // R1: operands cleared by reset show through OR of zeros
        en = 1'b1;
        drive(4'h0, 4'h0, 1'b0, 1'b1);
        rise_step();
        check("R1 cleared operands", c_slow, 4'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule